// File: doc/BRIEF.md
# Cascadable Fall-Through FIFO Stage

This block is a first-in first-out buffer of 64 words of 4 bits. A word that is strobed in does not appear at the output at once. It falls through a chain of internal slots, one slot per clock, until it reaches the output slot or the last free slot. When a word is taken from the output, the vacancy it leaves climbs back toward the input the same way. The ready flags therefore report fill and vacancy at the two ends of the chain only after this ripple delay.

Both sides use a strobe/ready handshake. A word enters when the shift-in strobe is high on a clock where input-ready is high. A word leaves when the shift-out strobe is high on a clock where output-ready is high. Two stages chain with no glue logic. The upstream output-ready drives the downstream shift-in, the downstream input-ready drives the upstream shift-out, and the upstream data output feeds the downstream data input. The pair then behaves as one 128-word buffer.

Top module: `ft_fifo_stage`

## Requirements
- R1: While the synchronous reset `rst` is high, every slot is emptied and the data registers are cleared. After reset, `in_ready` is 1, `out_ready` is 0 and `dout` is 0.
- R2: With no shift-out, the stage accepts exactly DEPTH (64) words. After that, `in_ready` stays 0 and `out_ready` is 1.
- R3: A shift-in strobe on a clock where `in_ready` is 0 stores nothing. No extra word later reaches the output.
- R4: On an empty stage, a word accepted at clock edge n raises `out_ready` at edge n+DEPTH-1. The word then appears on `dout`.
- R5: Words leave in the order they entered. While `out_ready` is 1 and no shift-out is accepted, `dout` and `out_ready` hold their values.
- R6: After the last word is shifted out, `out_ready` is 0 and `dout` keeps that last word. A shift-out strobe while `out_ready` is 0 has no effect.
- R7: On a full stage with no shift-in, a shift-out accepted at edge m raises `in_ready` at edge m+DEPTH-1, when the vacancy reaches the input slot.
- R8: After each accepted shift-in, `in_ready` is 0 on the next cycle. While shift-in is held high on a full stage, each arriving vacancy gives one single-cycle `in_ready` pulse and admits exactly one word.
- R9: A shift-in and a shift-out on the same clock are both honoured.
- R10: Two stages chained through the handshake accept 2*DEPTH (128) words before the upstream `in_ready` stays 0. They deliver all the words in order at the downstream output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous master reset, active high |
| shift_in | input | 1 | Shift-in strobe |
| din | input | WIDTH | Word to store |
| shift_out | input | 1 | Shift-out strobe |
| in_ready | output | 1 | Input slot is free |
| out_ready | output | 1 | Output slot holds a valid word |
| dout | output | WIDTH | Word in the output slot; the last word is kept after draining |

## Verification
Suppose an occupancy bit in the chain is wrong. A phantom word shows up as an extra or out-of-order word at `dout` about DEPTH cycles later. A lost word shows up as a missing one after the same delay. A slot that never frees keeps `in_ready` low past the expected edge m+DEPTH-1. The ready-flag latencies are measured to the exact cycle, so a move rule that skips or stalls a slot shifts the edge by at least one clock. A data register that is reloaded at the wrong time shows up on the very next clock, as a change of `dout` while the output slot is held.

// File: rtl/ft_pkg.sv
package ft_pkg;

  // A word moves from one slot to the next when the source holds a word
  // and the destination is free at the start of the clock.
  function automatic logic ft_moves(input logic src_full, input logic dst_full);
    return src_full & ~dst_full;
  endfunction

  // Occupancy update for a single slot.
  function automatic logic ft_next_full(input logic full, input logic fill, input logic drain);
    if (fill)       return 1'b1;
    else if (drain) return 1'b0;
    else            return full;
  endfunction

endpackage

// File: rtl/ft_cell.sv
module ft_cell #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  input  logic [WIDTH-1:0] d_in,
  output logic             valid,
  output logic [WIDTH-1:0] d_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      d_out <= '0;
    end else begin
      valid <= ft_pkg::ft_next_full(valid, take, give);
      if (take) d_out <= d_in;
    end
  end

endmodule

// File: rtl/ft_edge.sv
module ft_edge (
  input  logic shift_in,
  input  logic shift_out,
  input  logic first_full,
  input  logic last_full,
  output logic in_ready,
  output logic out_ready,
  output logic acc_in,
  output logic acc_out
);

  assign in_ready  = ~first_full;
  assign out_ready = last_full;
  assign acc_in    = shift_in & ~first_full;
  assign acc_out   = shift_out & last_full;

endmodule

// File: rtl/ft_fifo_stage.sv
module ft_fifo_stage #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_out,
  output logic             in_ready,
  output logic             out_ready,
  output logic [WIDTH-1:0] dout
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld;
  logic [DEPTH-1:0] take;
  logic [DEPTH-1:0] give;
  logic [WIDTH-1:0] dat [DEPTH];
  logic             acc_in;
  logic             acc_out;

  ft_edge u_edge (
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .first_full(vld[0]),
    .last_full (vld[LAST]),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .acc_in    (acc_in),
    .acc_out   (acc_out)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [WIDTH-1:0] src;
    if (g == 0) begin : g_head
      assign take[g] = acc_in;
      assign src     = din;
    end else begin : g_body
      assign take[g] = ft_pkg::ft_moves(vld[g-1], vld[g]);
      assign src     = dat[g-1];
    end
    if (g == LAST) begin : g_tail
      assign give[g] = acc_out;
    end else begin : g_pass
      assign give[g] = ft_pkg::ft_moves(vld[g], vld[g+1]);
    end
    ft_cell #(.WIDTH(WIDTH)) u_cell (
      .clk  (clk),
      .rst  (rst),
      .take (take[g]),
      .give (give[g]),
      .d_in (src),
      .valid(vld[g]),
      .d_out(dat[g])
    );
  end

  assign dout = dat[LAST];

endmodule

// File: rtl/ft_fifo_stage_chk.sv
module ft_fifo_stage_chk #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             out_ready,
  input logic [WIDTH-1:0] dout,
  input logic             acc_in,
  input logic             acc_out
);

  localparam int CW = $clog2(DEPTH + 1) + 1;

  logic [CW-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) held <= '0;
    else     held <= held + CW'(acc_in) - CW'(acc_out);
  end

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_ready && dout == '0));

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    held <= CW'(DEPTH));

  // R2
  full_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (held == CW'(DEPTH)) |-> !in_ready);

  // R4
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (held == '0) |-> !out_ready);

  // R5
  held_word_chk: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !acc_out) |=> (out_ready && $stable(dout)));

  // R6
  keep_last_chk: assert property (@(posedge clk) disable iff (rst)
    !out_ready |=> (out_ready || $stable(dout)));

  // R8
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    acc_in |=> !in_ready);

endmodule

bind ft_fifo_stage ft_fifo_stage_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .out_ready(out_ready),
  .dout     (dout),
  .acc_in   (acc_in),
  .acc_out  (acc_out)
);

// File: tb/test_ft_fifo_stage.sv
module test_ft_fifo_stage;

  localparam int W = 4;
  localparam int D = 64;

  logic clk = 0;
  logic rst;
  always #2.5 clk = ~clk;

  // single stage
  logic s_si, s_so, s_ir, s_or;
  logic [W-1:0] s_din, s_dout;
  // chained pair
  logic c_si, c_so, c_ir, c_or, m_rdy, m_vld;
  logic [W-1:0] c_din, c_dout, m_dat;

  ft_fifo_stage #(.WIDTH(W), .DEPTH(D)) i_ft_fifo_stage (
    .clk(clk), .rst(rst), .shift_in(s_si), .din(s_din), .shift_out(s_so),
    .in_ready(s_ir), .out_ready(s_or), .dout(s_dout));

  ft_fifo_stage #(.WIDTH(W), .DEPTH(D)) i_up (
    .clk(clk), .rst(rst), .shift_in(c_si), .din(c_din), .shift_out(m_rdy),
    .in_ready(c_ir), .out_ready(m_vld), .dout(m_dat));

  ft_fifo_stage #(.WIDTH(W), .DEPTH(D)) i_dn (
    .clk(clk), .rst(rst), .shift_in(m_vld), .din(m_dat), .shift_out(c_so),
    .in_ready(m_rdy), .out_ready(c_or), .dout(c_dout));

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [W-1:0] sq[$];
  logic [W-1:0] cq[$];

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scoreboard monitors: the value on dout at an accepting edge is the word leaving
  always @(posedge clk) begin
    if (!rst && s_so && s_or) begin
      if (sq.size() == 0) chk("R3 extra word", 0, int'(s_dout), -1);
      else begin
        logic [W-1:0] e;
        e = sq.pop_front();
        chk("R5 order", s_dout === e, int'(s_dout), int'(e));
      end
    end
    if (!rst && c_so && c_or) begin
      if (cq.size() == 0) chk("R10 extra word", 0, int'(c_dout), -1);
      else begin
        logic [W-1:0] e;
        e = cq.pop_front();
        chk("R10 order", c_dout === e, int'(c_dout), int'(e));
      end
    end
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      chk("watchdog", 0, 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  int kk, n, acc, both;

  initial begin
    rst = 1; s_si = 0; s_so = 0; s_din = 0; c_si = 0; c_so = 0; c_din = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk("R1 in_ready", s_ir === 1'b1, int'(s_ir), 1);
    chk("R1 out_ready", s_or === 1'b0, int'(s_or), 0);
    chk("R1 dout", s_dout === '0, int'(s_dout), 0);
    chk("R1 chain ready", c_ir === 1'b1 && c_or === 1'b0, int'({c_ir, c_or}), 2);

    // R4: fall-through latency of one word
    s_din = 4'd5; s_si = 1; sq.push_back(4'd5);
    kk = 0;
    do begin
      @(negedge clk); s_si = 0; kk++;
    end while (!s_or && kk < 200);
    chk("R4 latency", kk == D, kk, D);
    chk("R4 word", s_dout === 4'd5, int'(s_dout), 5);

    // R6: drain, last word kept, extra shift-out ignored
    s_so = 1; @(negedge clk); s_so = 0;
    chk("R6 empty", s_or === 1'b0, int'(s_or), 0);
    s_so = 1; repeat (3) @(negedge clk); s_so = 0;
    chk("R6 dout kept", s_dout === 4'd5, int'(s_dout), 5);
    chk("R6 still empty", s_or === 1'b0 && sq.size() == 0, sq.size(), 0);

    // R2: fill with shift-in held
    n = 0;
    for (int c = 0; c < 500; c++) begin
      s_si = 1; s_din = W'(n);
      if (s_ir) begin sq.push_back(W'(n)); n++; end
      @(negedge clk);
    end
    s_si = 0;
    chk("R2 capacity", n == D, n, D);
    chk("R2 full flags", s_ir === 1'b0 && s_or === 1'b1, int'({s_ir, s_or}), 1);
    // R3: strobes while full store nothing
    s_din = 4'hF; s_si = 1; repeat (5) @(negedge clk); s_si = 0;
    chk("R3 still full", s_ir === 1'b0, int'(s_ir), 0);

    // R7: vacancy climbs to the input slot
    s_so = 1; @(negedge clk); s_so = 0; kk = 1;
    while (!s_ir && kk < 200) begin @(negedge clk); kk++; end
    chk("R7 vacancy latency", kk == D, kk, D);

    // R8: shift-in held, one word per arriving vacancy
    acc = 0;
    for (int c = 0; c < 150; c++) begin
      s_si = 1; s_din = 4'd9; s_so = (c == 0);
      if (s_ir) begin sq.push_back(4'd9); acc++; end
      @(negedge clk);
    end
    s_si = 0; s_so = 0;
    chk("R8 one word per vacancy", acc == 2, acc, 2);
    chk("R8 full again", s_ir === 1'b0, int'(s_ir), 0);

    // R9: simultaneous shift-in and shift-out
    s_so = 1; repeat (40) @(negedge clk);
    both = 0; n = 0;
    for (int c = 0; c < 300; c++) begin
      s_si = 1; s_so = 1; s_din = W'(n + 3);
      if (s_ir) begin sq.push_back(W'(n + 3)); n++; if (s_or) both++; end
      @(negedge clk);
    end
    s_si = 0;
    chk("R9 both accepted", both > 0, both, 1);
    repeat (400) @(negedge clk);
    s_so = 0;
    // R3 R5: nothing extra, nothing lost
    chk("R5 all delivered", sq.size() == 0 && s_or === 1'b0, sq.size(), 0);

    // R10: chained pair holds 2*D words
    n = 0;
    for (int c = 0; c < 1000; c++) begin
      c_si = 1; c_din = W'(n);
      if (c_ir) begin cq.push_back(W'(n)); n++; end
      @(negedge clk);
    end
    c_si = 0;
    chk("R10 capacity", n == 2 * D, n, 2 * D);
    chk("R10 full", c_ir === 1'b0 && c_or === 1'b1, int'({c_ir, c_or}), 1);
    c_so = 1; repeat (700) @(negedge clk); c_so = 0;
    chk("R10 drained", cq.size() == 0 && c_or === 1'b0, cq.size(), 0);
    chk("R10 last word kept", c_dout === W'(2 * D - 1), int'(c_dout), (2 * D - 1) % 16);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule